// File: doc/BRIEF.md
# Power-Up Initialization Sequencer

This block brings a peripheral out of power-on reset and fills its register file with defaults while blocking host writes. The supply-good input `supplyGood` is used as an asynchronous active-low reset. While it is low, every register in the block is held cleared.

On the first clock edge after `supplyGood` rises, the block sets the oscillator-enable status bit. It then loads one default value per cycle into its register file. It keeps the enable bit high until a fixed phase has run its course. At that point it clears the bit and settles in a low-power idle state, with `ready` high.

The phase length is computed from the clock frequency in kHz and the phase duration in microseconds. The defaults give 550 µs at 250 MHz. While the phase runs, the host cannot write, but it can read at any time. This lets the host poll the enable bit to learn when start-up has finished.

Top module: `pwrup_init_seq`

## Requirements
- R1: While `supplyGood` is low, `oscEn`, `ready`, `initStb` and `rdData` are 0. All register-file entries are cleared to 0, so a register read before its default load returns 0.
- R2: On the first rising clock edge after `supplyGood` goes high, `oscEn` becomes 1. A status read (address 0) during the phase returns 1 in bit 0.
- R3: During the 1st to NREGS-th cycles after that edge, register i is loaded in ascending index order. It is loaded at the end of the (i+1)-th cycle. `initStb` is one-hot with bit i high during that cycle and 0 at all other times. The default of register i is (0x3C + 0x25·i) truncated to DW bits (0x3C, 0x61, 0x86, 0xAB for four 8-bit registers).
- R4: `oscEn` stays 1 for exactly PHASE_CYCLES = CLK_KHZ·PHASE_US/1000 clock cycles. On the same edge that clears it, `ready` rises. `ready` then stays 1 until `supplyGood` falls.
- R5: A write strobe while `ready` is 0 has no effect on any register.
- R6: A read strobe is served at any time. `rdData` takes the value at `addr` on the clock edge that samples `rdStb`, using the contents from before that edge. Address 0 returns `oscEn` in bit 0 with the other bits 0. Address i+1 returns register i. Addresses above NREGS return 0.
- R7: When `ready` is 1, a write strobe stores `wrData` into register addr−1 for addr 1..NREGS. Writes to address 0 or above NREGS change nothing.
- R8: A fall of `supplyGood` at any point, including mid-phase, clears the block at once. The next rise restarts the full sequence, and the defaults replace any earlier host writes.
- R9: `rdData` holds its value in cycles without a read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| supplyGood | input | 1 | Supply-good, asynchronous active-low reset of the whole block |
| wrStb | input | 1 | Host write strobe, one cycle per write |
| rdStb | input | 1 | Host read strobe, one cycle per read |
| addr | input | AW | Host address: 0 = status, 1..NREGS = register file |
| wrData | input | DW | Host write data |
| rdData | output | DW | Registered host read data |
| oscEn | output | 1 | Oscillator-enable status, high during the start-up phase |
| ready | output | 1 | High once start-up has completed |
| initStb | output | NREGS | One-hot pulse marking the register being loaded with its default |

## Verification
The embedded properties assume that `supplyGood` is the only reset. They also assume it is released away from the rising clock edge, so the first sampled edge after release sees a clean power-off state. The strobes and the address are taken as known values at every rising edge. The bench therefore drives all host inputs and `supplyGood` on the falling edge. It keeps every strobe to a single cycle, and it raises or drops the supply only between rising edges, including one drop in the middle of the phase.

// File: rtl/pwrup_pkg.sv
package pwrup_pkg;

  typedef enum logic [1:0] {
    PH_OFF,
    PH_LOAD,
    PH_HOLD,
    PH_IDLE
  } phase_t;

  // Strobes from the sequencer to the register datapath
  typedef struct packed {
    logic loadDef;
    logic hostWr;
    logic hostRd;
  } dpCmd_t;

  // Default value of register i, computed rather than tabulated
  function automatic logic [31:0] defaultOf(input int unsigned i);
    return 32'h3C + 32'h25 * 32'(i);
  endfunction

endpackage

// File: rtl/pwrup_ctrl.sv
module pwrup_ctrl
  import pwrup_pkg::*;
#(
  parameter int NREGS        = 4,
  parameter int PHASE_CYCLES = 137500,
  parameter int IW           = 2
) (
  input  logic          clk,
  input  logic          supplyGood,
  input  logic          wrStb,
  input  logic          rdStb,
  output logic          oscEn,
  output logic          ready,
  output dpCmd_t        cmd,
  output logic [IW-1:0] loadIdx
);

  localparam int CW = $clog2(PHASE_CYCLES + 1);
  localparam logic [CW-1:0] LAST_CNT = CW'(PHASE_CYCLES - 1);
  localparam logic [IW-1:0] LAST_IDX = IW'(NREGS - 1);

  phase_t        phase;
  logic [CW-1:0] cnt;
  logic [IW-1:0] idx;

  always_ff @(posedge clk or negedge supplyGood) begin
    if (!supplyGood) begin
      phase <= PH_OFF;
      cnt   <= '0;
      idx   <= '0;
    end else begin
      unique case (phase)
        PH_OFF: phase <= PH_LOAD;
        PH_LOAD: begin
          cnt <= cnt + 1'b1;
          if (idx == LAST_IDX) begin
            idx   <= '0;
            phase <= PH_HOLD;
          end else begin
            idx <= idx + 1'b1;
          end
        end
        PH_HOLD: begin
          cnt <= cnt + 1'b1;
          if (cnt == LAST_CNT) phase <= PH_IDLE;
        end
        PH_IDLE: phase <= PH_IDLE;
        default: phase <= PH_OFF;
      endcase
    end
  end

  assign oscEn       = (phase == PH_LOAD) || (phase == PH_HOLD);
  assign ready       = (phase == PH_IDLE);
  assign loadIdx     = idx;
  assign cmd.loadDef = (phase == PH_LOAD);
  assign cmd.hostWr  = ready && wrStb;
  assign cmd.hostRd  = rdStb;

  // R2: power-off state is always followed by the enable bit
  assert_osc_start_R2: assert property (@(posedge clk) disable iff (!supplyGood)
    (!oscEn && !ready) |=> oscEn);

  // R4: phase ends exactly on the terminal count
  assert_phase_end_R4: assert property (@(posedge clk) disable iff (!supplyGood)
    (oscEn && cnt == LAST_CNT) |=> (ready && !oscEn));

  // R4: no early end of the phase
  assert_phase_hold_R4: assert property (@(posedge clk) disable iff (!supplyGood)
    (oscEn && cnt != LAST_CNT) |=> (oscEn && !ready));

  // R4: ready is sticky while the supply is good
  assert_ready_sticky_R4: assert property (@(posedge clk) disable iff (!supplyGood)
    ready |=> ready);

endmodule

// File: rtl/pwrup_dp.sv
module pwrup_dp
  import pwrup_pkg::*;
#(
  parameter int NREGS = 4,
  parameter int DW    = 8,
  parameter int AW    = 3,
  parameter int IW    = 2
) (
  input  logic             clk,
  input  logic             supplyGood,
  input  dpCmd_t           cmd,
  input  logic [IW-1:0]    loadIdx,
  input  logic             oscEn,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wrData,
  output logic [DW-1:0]    rdData,
  output logic [NREGS-1:0] initStb
);

  logic [NREGS-1:0][DW-1:0] regs;
  logic [DW-1:0]            rdMux;

  for (genvar i = 0; i < NREGS; i++) begin : g_reg
    localparam logic [DW-1:0] DEF = DW'(defaultOf(i));
    logic hit;
    assign hit        = cmd.loadDef && (loadIdx == IW'(i));
    assign initStb[i] = hit;

    always_ff @(posedge clk or negedge supplyGood) begin
      if (!supplyGood)                          regs[i] <= '0;
      else if (hit)                             regs[i] <= DEF;
      else if (cmd.hostWr && addr == AW'(i + 1)) regs[i] <= wrData;
    end
  end

  always_comb begin
    rdMux = '0;
    if (addr == '0) rdMux[0] = oscEn;
    for (int i = 0; i < NREGS; i++) begin
      if (addr == AW'(i + 1)) rdMux = regs[i];
    end
  end

  always_ff @(posedge clk or negedge supplyGood) begin
    if (!supplyGood)     rdData <= '0;
    else if (cmd.hostRd) rdData <= rdMux;
  end

  // R3: at most one register loaded per cycle
  assert_onehot_R3: assert property (@(posedge clk) disable iff (!supplyGood)
    $onehot0(initStb));

  // R5: registers move only on a default load or a permitted write
  assert_regs_hold_R5: assert property (@(posedge clk) disable iff (!supplyGood)
    (!cmd.loadDef && !cmd.hostWr) |=> $stable(regs));

  // R9: read data holds without a read strobe
  assert_rd_hold_R9: assert property (@(posedge clk) disable iff (!supplyGood)
    !cmd.hostRd |=> $stable(rdData));

endmodule

// File: rtl/pwrup_init_seq.sv
module pwrup_init_seq
  import pwrup_pkg::*;
#(
  parameter int CLK_KHZ  = 250000,
  parameter int PHASE_US = 550,
  parameter int NREGS    = 4,
  parameter int DW       = 8,
  parameter int AW       = $clog2(NREGS + 1)
) (
  input  logic             clk,
  input  logic             supplyGood,
  input  logic             wrStb,
  input  logic             rdStb,
  input  logic [AW-1:0]    addr,
  input  logic [DW-1:0]    wrData,
  output logic [DW-1:0]    rdData,
  output logic             oscEn,
  output logic             ready,
  output logic [NREGS-1:0] initStb
);

  localparam int PHASE_CYCLES = CLK_KHZ * PHASE_US / 1000;
  localparam int IW           = (NREGS > 1) ? $clog2(NREGS) : 1;

  dpCmd_t        cmd;
  logic [IW-1:0] loadIdx;

  pwrup_ctrl #(
    .NREGS(NREGS), .PHASE_CYCLES(PHASE_CYCLES), .IW(IW)
  ) u_ctrl (
    .clk(clk), .supplyGood(supplyGood), .wrStb(wrStb), .rdStb(rdStb),
    .oscEn(oscEn), .ready(ready), .cmd(cmd), .loadIdx(loadIdx)
  );

  pwrup_dp #(
    .NREGS(NREGS), .DW(DW), .AW(AW), .IW(IW)
  ) u_dp (
    .clk(clk), .supplyGood(supplyGood), .cmd(cmd), .loadIdx(loadIdx),
    .oscEn(oscEn), .addr(addr), .wrData(wrData), .rdData(rdData),
    .initStb(initStb)
  );

endmodule

// File: tb/pwrup_init_seq_tb.sv
`timescale 1ns/1ps
module pwrup_init_seq_tb;

  localparam int CLK_KHZ = 100;
  localparam int PH_US   = 550;
  localparam int P       = CLK_KHZ * PH_US / 1000; // 55 cycles
  localparam int NR      = 4;
  localparam int DW      = 8;
  localparam int AW      = 3;

  logic clk = 1'b0;
  logic supplyGood = 1'b0;
  logic wr = 1'b0, rd = 1'b0;
  logic [AW-1:0] ad = '0;
  logic [DW-1:0] wd = '0;
  logic [DW-1:0] rdData;
  logic oscEn, ready;
  logic [NR-1:0] initStb;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  pwrup_init_seq #(
    .CLK_KHZ(CLK_KHZ), .PHASE_US(PH_US), .NREGS(NR), .DW(DW), .AW(AW)
  ) u_dut (
    .clk(clk), .supplyGood(supplyGood), .wrStb(wr), .rdStb(rd), .addr(ad),
    .wrData(wd), .rdData(rdData), .oscEn(oscEn), .ready(ready), .initStb(initStb)
  );

  // {wr, rd, addr[2:0], wdata[7:0], expected rdata[7:0]}
  localparam int NV = 14;
  localparam logic [20:0] VEC [NV] = '{
    {1'b0, 1'b1, 3'd1, 8'h00, 8'h3C}, // R5: write during phase was ignored
    {1'b0, 1'b1, 3'd2, 8'h00, 8'h61}, // R3 default
    {1'b0, 1'b1, 3'd3, 8'h00, 8'h86}, // R3 default
    {1'b0, 1'b1, 3'd4, 8'h00, 8'hAB}, // R3 default
    {1'b0, 1'b1, 3'd0, 8'h00, 8'h00}, // R6 status after done
    {1'b1, 1'b0, 3'd2, 8'h5A, 8'h00}, // R7 write
    {1'b0, 1'b1, 3'd2, 8'h00, 8'h5A}, // R7 readback
    {1'b1, 1'b0, 3'd0, 8'hFF, 8'h00}, // R7 write to status
    {1'b0, 1'b1, 3'd0, 8'h00, 8'h00}, // R7 status unchanged
    {1'b1, 1'b0, 3'd5, 8'h77, 8'h00}, // R7 out-of-range write
    {1'b0, 1'b1, 3'd5, 8'h00, 8'h00}, // R6 out-of-range read
    {1'b0, 1'b1, 3'd1, 8'h00, 8'h3C}, // R7 no side effect
    {1'b1, 1'b1, 3'd4, 8'hC3, 8'hAB}, // R6 read sees pre-edge value
    {1'b0, 1'b1, 3'd4, 8'h00, 8'hC3}  // R7 readback
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  // Raise the supply and follow the whole phase edge by edge
  task automatic bringUp(input bit probe);
    supplyGood = 1'b1;
    for (int n = 1; n <= P + 2; n++) begin
      step();
      chk("R4 oscEn", oscEn, (n <= P) ? 1 : 0);
      chk("R4 ready", ready, (n > P) ? 1 : 0);
      chk("R3 initStb", initStb, (n <= NR) ? (1 << (n - 1)) : 0);
      if (n == 1) chk("R2 oscEn first edge", oscEn, 1);
      if (probe) begin
        if (n == 2) chk("R1 register cleared before load", rdData, 8'h00);
        if (n == 4) chk("R2 status bit0 during phase", rdData, 8'h01);
        if (n == 6) chk("R3 last default loaded", rdData, 8'hAB);
      end
      wr = 1'b0;
      rd = 1'b0;
      if (probe) begin
        case (n)
          1:  begin rd = 1'b1; ad = 3'd1; end
          3:  begin rd = 1'b1; ad = 3'd0; end
          5:  begin rd = 1'b1; ad = 3'd4; end
          10: begin wr = 1'b1; ad = 3'd1; wd = 8'hFF; end // R5 blocked write
          default: ;
        endcase
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 oscEn", oscEn, 0);
    chk("R1 ready", ready, 0);
    chk("R1 initStb", initStb, 0);
    chk("R1 rdData", rdData, 0);

    bringUp(1'b1);

    for (int k = 0; k < NV; k++) begin
      wr = VEC[k][20];
      rd = VEC[k][19];
      ad = VEC[k][18:16];
      wd = VEC[k][15:8];
      step();
      wr = 1'b0;
      rd = 1'b0;
      if (VEC[k][19]) chk($sformatf("R6/R7 vector %0d", k), rdData, VEC[k][7:0]);
    end

    // R9 hold without strobe
    ad = 3'd1;
    step();
    step();
    chk("R9 rdData held", rdData, 8'hC3);

    // R8 drop after ready
    supplyGood = 1'b0;
    #1;
    chk("R8 oscEn after drop", oscEn, 0);
    chk("R8 ready after drop", ready, 0);
    chk("R8 rdData after drop", rdData, 0);
    step();
    bringUp(1'b0);
    rd = 1'b1; ad = 3'd2;
    step();
    rd = 1'b0;
    chk("R8 host write replaced by default", rdData, 8'h61);

    // R8 drop in mid-phase
    supplyGood = 1'b0;
    step();
    supplyGood = 1'b1;
    repeat (20) step();
    chk("R8 oscEn mid-phase", oscEn, 1);
    supplyGood = 1'b0;
    #1;
    chk("R8 oscEn cleared mid-phase", oscEn, 0);
    step();
    chk("R8 still off while low", oscEn, 0);
    bringUp(1'b0);
    chk("R4 ready after restart", ready, 1);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule